// File: doc/BRIEF.md
# XOR Phase Detector Digital PLL with Modulus-K Loop Filter

This block is an all-digital phase-locked loop clocked by a fast system clock. A one-bit phase error is formed by the exclusive-OR of the reference input and the loop output. A modulus-K up/down counter integrates that error and emits single-cycle advance (carry) and retard (borrow) pulses. These pulses steer a pulse-stream oscillator. In steady state the oscillator emits one pulse every second clock. A carry adds one extra pulse and a borrow removes one. A divide-by-N counter follows the oscillator, and its output is both the loop output and the feedback signal.

At the centre frequency the reference period is 2·N fast clocks. The loop settles with the output lagging the reference by a quarter period, where the XOR output has a 50% duty cycle and carries and borrows balance. A lock flag is refreshed once per fixed window of fast clocks. It is set when the reference toggled during the window and the carry and borrow counts of that window differ by no more than a tolerance.

Top module: `xor_kcnt_dpll`

## Requirements
- R1: While rst_n is low and on the first cycle after it, dpll_out, locked, carry_pulse and borrow_pulse are 0, and every internal counter restarts from zero.
- R2: The phase error is ref_in XOR dpll_out. On each clock the K-counter (range 0..K_MOD-1) steps up by one when the error is 1 and down by one when it is 0.
- R3: A step up from K_MOD-1 wraps the counter to 0 and raises carry_pulse for exactly the next clock cycle. A step down from 0 wraps it to K_MOD-1 and raises borrow_pulse for exactly the next clock cycle. The two pulses are never high together.
- R4: With no pending correction, the pulse oscillator emits one pulse every second clock. Its phase bit starts at 0 after reset and toggles every clock, and a pulse is emitted while the phase bit is 1.
- R5: A carry pulse arms an insertion. The insertion emits one extra oscillator pulse in the next cycle whose phase bit is 0, and the arming is then cleared.
- R6: A borrow pulse arms a deletion. The deletion suppresses the pulse of the next cycle whose phase bit is 1, and the arming is then cleared.
- R7: If an insertion and a deletion are armed at the same time, both are cancelled and neither affects the pulse stream.
- R8: The divide-by-N counter advances by one per oscillator pulse and wraps from N_DIV-1 to 0. dpll_out is 1 while the count is at least N_DIV/2.
- R9: The lock flag changes only on the last cycle of each LOCK_WIN-clock window. It becomes 1 when ref_in changed during the window and the window's carry and borrow counts differ by at most LOCK_TOL, and 0 otherwise. With a reference at the centre frequency, the loop reaches locked = 1.
- R10: A reference slower than the centre frequency produces more borrow pulses than carry pulses. A faster one produces more carry pulses than borrow pulses.
- R11: While ref_in is held constant, locked stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast loop clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference square wave, synchronous to clk |
| dpll_out | output | 1 | Divide-by-N loop output, also the feedback signal |
| locked | output | 1 | Lock indication, refreshed once per window |
| carry_pulse | output | 1 | One-cycle pulse on K-counter overflow |
| borrow_pulse | output | 1 | One-cycle pulse on K-counter underflow |

## Verification
The assertions assume that ref_in is already synchronous to clk and that K_MOD is at least 4. With K_MOD of at least 4, two carries or two borrows can never arrive close enough to arm a second correction before the first is used. They also assume that reset is held low for at least one clock before release. The stimulus changes ref_in only at falling clock edges and uses the default K_MOD of 8. It holds reset for several cycles before each scenario. Its reference periods (16, 18 and 14 clocks) stay within the rate the loop can correct, so pending corrections never pile up.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  // Output of the divide-by-N stage: high for the upper half of the count.
  function automatic bit div_is_high(input int unsigned count, input int unsigned n);
    return count >= (n / 2);
  endfunction

  // Balance test used by the lock window.
  function automatic bit balance_ok(input int unsigned ups, input int unsigned downs,
                                    input int unsigned tol);
    int unsigned gap;
    gap = (ups > downs) ? (ups - downs) : (downs - ups);
    return gap <= tol;
  endfunction

  // Modulus-K step: returns the next count value.
  function automatic int unsigned kmod_next(input int unsigned count, input bit up,
                                            input int unsigned k);
    if (up) return (count == k - 1) ? 0 : count + 1;
    else    return (count == 0) ? k - 1 : count - 1;
  endfunction

endpackage

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter #(
  parameter int K_MOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_up,
  output logic carry_o,
  output logic borrow_o
);
  import dpll_pkg::*;

  localparam int KW = (K_MOD > 1) ? $clog2(K_MOD) : 1;
  localparam logic [KW-1:0] KTOP = KW'(K_MOD - 1);

  logic [KW-1:0] kcnt;
  logic          wrap_up;
  logic          wrap_dn;

  assign wrap_up = err_up && (kcnt == KTOP);
  assign wrap_dn = !err_up && (kcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kcnt     <= '0;
      carry_o  <= 1'b0;
      borrow_o <= 1'b0;
    end else begin
      kcnt     <= KW'(kmod_next(int'(kcnt), err_up, K_MOD));
      carry_o  <= wrap_up;
      borrow_o <= wrap_dn;
    end
  end

  // R3: after an overflow pulse the counter reads zero
  assert_carry_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (kcnt == '0));
  // R3: after an underflow pulse the counter reads its top value
  assert_borrow_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_o |-> (kcnt == KTOP));
  // R3: pulses last a single cycle
  assert_carry_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);
  // R2: counter moves by exactly one step per clock
  assert_kcnt_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (kcnt != $past(kcnt)));

endmodule

// File: rtl/dpll_id_counter.sv
module dpll_id_counter (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_i,
  input  logic borrow_i,
  output logic pulse_o
);
  logic phase;
  logic ins_armed;
  logic del_armed;
  logic ins_use;
  logic del_use;
  logic ins_nx;
  logic del_nx;

  assign ins_use = !phase && ins_armed;
  assign del_use = phase && del_armed;
  assign pulse_o = (phase && !del_armed) || ins_use;

  always_comb begin
    ins_nx = carry_i || (ins_armed && !ins_use);
    del_nx = borrow_i || (del_armed && !del_use);
    if (ins_nx && del_nx) begin
      ins_nx = 1'b0;
      del_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      ins_armed <= 1'b0;
      del_armed <= 1'b0;
    end else begin
      phase     <= ~phase;
      ins_armed <= ins_nx;
      del_armed <= del_nx;
    end
  end

  // R7: opposite corrections never stay armed together
  assert_no_dual_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_armed && del_armed));
  // R6: an armed deletion removes the pulse of a phase-1 cycle
  assert_delete_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && del_armed) |-> !pulse_o);
  // R5: an armed insertion is consumed within two cycles
  assert_insert_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && ins_armed && !borrow_i) |=> !ins_armed || carry_i);

endmodule

// File: rtl/dpll_divider.sv
module dpll_divider #(
  parameter int N_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic out_o
);
  import dpll_pkg::*;

  localparam int DW = (N_DIV > 1) ? $clog2(N_DIV) : 1;
  localparam logic [DW-1:0] DTOP = DW'(N_DIV - 1);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (pulse_i) begin
      dcnt <= (dcnt == DTOP) ? '0 : dcnt + 1'b1;
    end
  end

  assign out_o = div_is_high(int'(dcnt), N_DIV);

  // R8: the count stays in range
  assert_div_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= DTOP);
  // R8: the count moves only on an oscillator pulse
  assert_div_moves_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt != $past(dcnt)) |-> $past(pulse_i));

endmodule

// File: rtl/dpll_lock_detect.sv
module dpll_lock_detect #(
  parameter int LOCK_WIN = 256,
  parameter int LOCK_TOL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic carry_i,
  input  logic borrow_i,
  output logic locked_o
);
  import dpll_pkg::*;

  localparam int WW = (LOCK_WIN > 1) ? $clog2(LOCK_WIN) : 1;
  localparam int CW = $clog2(LOCK_WIN + 1);
  localparam logic [WW-1:0] WTOP = WW'(LOCK_WIN - 1);

  logic [WW-1:0] wcnt;
  logic [CW-1:0] ccnt;
  logic [CW-1:0] bcnt;
  logic [CW-1:0] c_tot;
  logic [CW-1:0] b_tot;
  logic          ref_q;
  logic          seen;
  logic          ref_edge;
  logic          win_end;

  assign ref_edge = ref_i ^ ref_q;
  assign c_tot    = ccnt + CW'(carry_i);
  assign b_tot    = bcnt + CW'(borrow_i);
  assign win_end  = (wcnt == WTOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt     <= '0;
      ccnt     <= '0;
      bcnt     <= '0;
      ref_q    <= 1'b0;
      seen     <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      ref_q <= ref_i;
      if (win_end) begin
        locked_o <= (seen || ref_edge) &&
                    balance_ok(int'(c_tot), int'(b_tot), LOCK_TOL);
        wcnt <= '0;
        ccnt <= '0;
        bcnt <= '0;
        seen <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
        ccnt <= c_tot;
        bcnt <= b_tot;
        seen <= seen || ref_edge;
      end
    end
  end

  // R9: the flag only moves at a window boundary
  assert_lock_at_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o != $past(locked_o)) |-> ($past(wcnt) == WTOP));
  // R11: no reference activity in a window means no lock after it
  assert_no_lock_without_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !seen && !ref_edge) |=> !locked_o);

endmodule

// File: rtl/xor_kcnt_dpll.sv
module xor_kcnt_dpll #(
  parameter int K_MOD    = 8,
  parameter int N_DIV    = 8,
  parameter int LOCK_WIN = 256,
  parameter int LOCK_TOL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic dpll_out,
  output logic locked,
  output logic carry_pulse,
  output logic borrow_pulse
);
  logic phase_err;
  logic id_pulse;

  assign phase_err = ref_in ^ dpll_out;

  dpll_loop_filter #(.K_MOD(K_MOD)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_up  (phase_err),
    .carry_o (carry_pulse),
    .borrow_o(borrow_pulse)
  );

  dpll_id_counter u_idc (
    .clk     (clk),
    .rst_n   (rst_n),
    .carry_i (carry_pulse),
    .borrow_i(borrow_pulse),
    .pulse_o (id_pulse)
  );

  dpll_divider #(.N_DIV(N_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .pulse_i(id_pulse),
    .out_o  (dpll_out)
  );

  dpll_lock_detect #(.LOCK_WIN(LOCK_WIN), .LOCK_TOL(LOCK_TOL)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_i   (ref_in),
    .carry_i (carry_pulse),
    .borrow_i(borrow_pulse),
    .locked_o(locked)
  );

  // R3: overflow and underflow are exclusive
  assert_no_carry_borrow_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_pulse && borrow_pulse));
  // R1: outputs are quiet in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!dpll_out && !locked && !carry_pulse && !borrow_pulse));

endmodule

// File: tb/xor_kcnt_dpll_tb.sv
`timescale 1ns/1ps
module xor_kcnt_dpll_tb;
  localparam int K = 8;
  localparam int N = 8;
  localparam int W = 256;
  localparam int TOL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic dpll_out, locked, carry_pulse, borrow_pulse;

  int checks = 0;
  int errors = 0;
  int n_car = 0;
  int n_bor = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xor_kcnt_dpll #(.K_MOD(K), .N_DIV(N), .LOCK_WIN(W), .LOCK_TOL(TOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dpll_out(dpll_out),
    .locked(locked), .carry_pulse(carry_pulse), .borrow_pulse(borrow_pulse)
  );

  // Behavioural expectation of the loop, kept as plain integers.
  int mk, md, mw, mc, mb;
  bit mcar, mbor, mph, mins, mdel, mrefq, mseen, mlock;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    mk = 0; md = 0; mw = 0; mc = 0; mb = 0;
    mcar = 0; mbor = 0; mph = 0; mins = 0; mdel = 0;
    mrefq = 0; mseen = 0; mlock = 0;
  endtask

  // Called at a falling edge: drive, compare, advance the expectation, wait.
  task automatic step(input bit r);
    bit o, x, pulse, ni, nd, ncar, nbor, ed;
    int tc, tb, gap;
    ref_in = r;
    o = (md >= N / 2);
    check("R4/R5/R6/R7/R8 dpll_out", int'(dpll_out), int'(o));
    check("R2/R3 carry_pulse", int'(carry_pulse), int'(mcar));
    check("R2/R3 borrow_pulse", int'(borrow_pulse), int'(mbor));
    check("R9 locked", int'(locked), int'(mlock));
    if (carry_pulse) n_car++;
    if (borrow_pulse) n_bor++;
    x = r ^ o;
    pulse = mph ? !mdel : mins;
    ncar = 0; nbor = 0;
    if (x) begin
      if (mk == K - 1) begin mk = 0; ncar = 1; end else mk = mk + 1;
    end else begin
      if (mk == 0) begin mk = K - 1; nbor = 1; end else mk = mk - 1;
    end
    ni = mcar || (mins && mph);
    nd = mbor || (mdel && !mph);
    if (ni && nd) begin ni = 0; nd = 0; end
    tc = mc + int'(mcar);
    tb = mb + int'(mbor);
    ed = (r != mrefq);
    if (mw == W - 1) begin
      gap = (tc > tb) ? tc - tb : tb - tc;
      mlock = (mseen || ed) && (gap <= TOL);
      mw = 0; mc = 0; mb = 0; mseen = 0;
    end else begin
      mw = mw + 1; mc = tc; mb = tb; mseen = mseen || ed;
    end
    mrefq = r;
    if (pulse) md = (md + 1) % N;
    mph = !mph; mins = ni; mdel = nd; mcar = ncar; mbor = nbor;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 dpll_out in reset", int'(dpll_out), 0);
    check("R1 locked in reset", int'(locked), 0);
    check("R1 carry in reset", int'(carry_pulse), 0);
    check("R1 borrow in reset", int'(borrow_pulse), 0);
    rst_n = 1'b1;
    model_clear();
    n_car = 0; n_bor = 0;
  endtask

  task automatic run_ref(input int period, input int cycles);
    for (int i = 0; i < cycles; i++) step(((i % period) < period / 2) ? 1'b1 : 1'b0);
  endtask

  task automatic t_idle();
    t_reset();
    for (int i = 0; i < 3 * W; i++) step(1'b0);
    check("R11 locked with constant reference", int'(locked), 0);
    for (int i = 0; i < 2 * W; i++) step(1'b1);
    check("R11 locked with reference held high", int'(locked), 0);
  endtask

  task automatic t_centre();
    t_reset();
    run_ref(2 * N, 16 * W);
    check("R9 locked at centre frequency", int'(locked), 1);
  endtask

  task automatic t_offset(input int period, input bit slow);
    int c0, b0;
    t_reset();
    run_ref(period, 2 * W);
    c0 = n_car; b0 = n_bor;
    run_ref(period, 8 * W);
    if (slow) check("R10 slow ref gives net borrows", int'((n_bor - b0) > (n_car - c0)), 1);
    else      check("R10 fast ref gives net carries", int'((n_car - c0) > (n_bor - b0)), 1);
  endtask

  initial begin
    t_reset();
    step(1'b0);
    t_idle();
    t_centre();
    t_offset(2 * N + 2, 1'b1);
    t_offset(2 * N - 2, 1'b0);
    t_reset();
    step(1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule